// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block gathers interrupt requests from level-sensitive hardware lines, from per-CPU private timer and watchdog inputs and from software-generated inter-processor messages. It presents each CPU with a single request line and the identifier of the most urgent interrupt that CPU may take now. Every interrupt has one enable bit and a 4-bit priority, where a smaller value is more urgent. Hardware lines carry a CPU mask that sends them to one CPU, to a group or to all CPUs. Priorities for identifiers below 32 are banked per CPU. A write to a hardware identifier's priority updates every CPU's copy.

The identifier space has fixed regions. IDs 0..15 are software interrupts, 29 is each CPU's private timer and 30 its private watchdog. Hardware line `h` is ID `32+h`. IDs 16..28 and 31 never become pending. Each (CPU, ID) pair runs its own state machine with three states: `CS_IDLE` (inactive), `CS_PEND` (pending) and `CS_ACT` (active). Its transitions are:
- *set*: `CS_IDLE` to `CS_PEND` when the source is asserted for that CPU.
- *withdraw*: `CS_PEND` to `CS_IDLE` when a level source drops before it is taken.
- *take*: `CS_PEND` to `CS_ACT` on an acknowledge that selects this ID.
- *finish*: `CS_ACT` to `CS_IDLE` on an end-of-interrupt naming this ID.

A CPU's running priority is the most urgent priority among its active IDs. A pending ID is signalled only if it is strictly more urgent than the running priority, which allows nested handling.

Configuration uses a one-cycle write port. `cfg_op` selects the operation: 0 sets the enable bit from `cfg_data[0]`; 1 sets the priority from `cfg_data[3:0]`; 2 sets a hardware ID's CPU mask from `cfg_data[NCPU-1:0]`; 3 raises software interrupt `cfg_id` on behalf of CPU `cfg_cpu`.

Top module: `mpid_top`

## Requirements
- R1: After reset every state is inactive, every `irq_req` bit is 0 and every `irq_id` field is all ones.
- R2: Hardware line `h` (ID `32+h`), while high, becomes pending one clock later on exactly the CPUs whose bit is set in its mask. If the line falls while the interrupt is still pending, it returns to inactive.
- R3: A pending interrupt whose enable bit is 0 is never signalled. Once the bit is set, it is signalled on the next cycle.
- R4: `irq_id` of a requesting CPU is the pending enabled ID with the smallest priority value. Equal priorities go to the lowest ID.
- R5: An acknowledge from a requesting CPU moves the presented ID from pending to active for that CPU only, at the next edge. An inactive interrupt never becomes active without first being pending.
- R6: While a CPU has active interrupts, it is requested only for a pending ID whose priority value is strictly smaller than the smallest active priority value. An equal value does not preempt.
- R7: An end-of-interrupt from a CPU returns the named active ID to inactive on that CPU alone. Other CPUs' states for the same ID are untouched. A still-high level source pends again one cycle later.
- R8: Software trigger mode `cfg_data[1:0]` selects the targets: 0 means the CPUs whose bits are set in `cfg_data[2+c]`, 1 means all CPUs except `cfg_cpu`, and 2 means only `cfg_cpu`. The trigger takes effect only when `cfg_id` < 16.
- R9: A software interrupt's priority is the target CPU's banked priority for that ID, not the sender's.
- R10: Timer input `c` pends ID 29 and watchdog input `c` pends ID 30, on CPU `c` only.
- R11: An acknowledge while `irq_req` is 0 has no effect. An end-of-interrupt naming an ID that is not active has no effect. `irq_id` is all ones whenever `irq_req` is 0.
- R12: An acknowledge and an end-of-interrupt on the same CPU in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_op | input | 2 | Operation: 0 enable, 1 priority, 2 CPU mask, 3 software trigger |
| cfg_cpu | input | CW | Banked CPU for priority writes; requesting CPU for software triggers |
| cfg_id | input | IW | Interrupt identifier |
| cfg_data | input | 8 | Write data |
| hw_irq | input | NHW | Level hardware interrupt lines |
| tmr_irq | input | NCPU | Per-CPU private timer level |
| wdg_irq | input | NCPU | Per-CPU private watchdog level |
| ack | input | NCPU | Per-CPU acknowledge pulse |
| eoi | input | NCPU | Per-CPU end-of-interrupt pulse |
| eoi_id | input | NCPU*IW | Per-CPU identifier being finished |
| irq_req | output | NCPU | Per-CPU interrupt request |
| irq_id | output | NCPU*IW | Per-CPU presented identifier, all ones when there is no request |

## Verification
The interesting coincidence is an acknowledge and an end-of-interrupt arriving at one CPU on the same edge. The acknowledge takes a new, more urgent ID while the end-of-interrupt releases the older active one. The bench sets this up with a low-urgency interrupt active and a high-urgency one pending, pulses both handshakes together, then finishes the newer one. A third pending interrupt, less urgent than the released one, is requested only if the older interrupt really left the active state. The random phase pulses both handshakes freely in the same cycles as configuration writes and line changes, and compares every cycle against a bench model.

// File: rtl/mpid_pkg.sv
`timescale 1ns/1ps
package mpid_pkg;
    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_PEND = 2'd1,
        CS_ACT  = 2'd2
    } cell_st_e;

    typedef enum logic [1:0] {
        OP_ENABLE = 2'd0,
        OP_PRIO   = 2'd1,
        OP_ROUTE  = 2'd2,
        OP_SGI    = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        SG_LIST   = 2'd0,
        SG_OTHERS = 2'd1,
        SG_SELF   = 2'd2,
        SG_NONE   = 2'd3
    } sgi_mode_e;

    localparam int PRIO_W  = 4;
    localparam int SGI_IDS = 16;
    localparam int TMR_ID  = 29;
    localparam int WDG_ID  = 30;
    localparam int HW_BASE = 32;
endpackage

// File: rtl/mpid_cfg.sv
`timescale 1ns/1ps
module mpid_cfg
    import mpid_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NHW  = 8,
    localparam int NID   = HW_BASE + NHW,
    localparam int IW    = $clog2(NID),
    localparam int CW    = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int HW_IW = (NHW > 1) ? $clog2(NHW) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_we,
    input  logic [1:0]                                cfg_op,
    input  logic [CW-1:0]                             cfg_cpu,
    input  logic [IW-1:0]                             cfg_id,
    input  logic [7:0]                                cfg_data,
    output logic [NID-1:0]                            en_o,
    output logic [NCPU-1:0][NID-1:0][PRIO_W-1:0]      prio_o,
    output logic [NHW-1:0][NCPU-1:0]                  route_o,
    output logic [NCPU-1:0][SGI_IDS-1:0]              sgi_o
);
    cfg_op_e          op_e;
    sgi_mode_e        mode_e;
    logic             id_ok, cpu_ok, is_hw;
    logic [HW_IW-1:0] hw_idx;

    assign op_e   = cfg_op_e'(cfg_op);
    assign mode_e = sgi_mode_e'(cfg_data[1:0]);
    assign id_ok  = {1'b0, cfg_id} < (IW+1)'(NID);
    assign cpu_ok = {1'b0, cfg_cpu} < (CW+1)'(NCPU);
    assign is_hw  = {1'b0, cfg_id} >= (IW+1)'(HW_BASE);
    assign hw_idx = HW_IW'(cfg_id - IW'(HW_BASE));

    // registered configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o    <= '0;
            prio_o  <= '0;
            route_o <= '0;
        end else if (cfg_we && id_ok) begin
            unique case (op_e)
                OP_ENABLE: en_o[cfg_id] <= cfg_data[0];
                OP_PRIO: begin
                    if (!is_hw) begin
                        if (cpu_ok) prio_o[cfg_cpu][cfg_id] <= cfg_data[PRIO_W-1:0];
                    end else begin
                        for (int c = 0; c < NCPU; c++) prio_o[c][cfg_id] <= cfg_data[PRIO_W-1:0];
                    end
                end
                OP_ROUTE: if (is_hw) route_o[hw_idx] <= cfg_data[NCPU-1:0];
                OP_SGI:   ;
            endcase
        end
    end

    // software trigger decode, same cycle as the write
    always_comb begin
        sgi_o = '0;
        if (cfg_we && op_e == OP_SGI && cpu_ok && {1'b0, cfg_id} < (IW+1)'(SGI_IDS)) begin
            for (int t = 0; t < NCPU; t++) begin
                unique case (mode_e)
                    SG_LIST:   sgi_o[t][cfg_id[3:0]] = cfg_data[2+t];
                    SG_OTHERS: sgi_o[t][cfg_id[3:0]] = (CW'(t) != cfg_cpu);
                    SG_SELF:   sgi_o[t][cfg_id[3:0]] = (CW'(t) == cfg_cpu);
                    SG_NONE:   sgi_o[t][cfg_id[3:0]] = 1'b0;
                endcase
            end
        end
    end

    AST_SGI_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_op == 2'd3 && cfg_data[1:0] == 2'd1 && cpu_ok |-> sgi_o[cfg_cpu] == '0); // R8
    AST_SGI_SELF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_op == 2'd3 && cfg_data[1:0] == 2'd2 && cpu_ok && cfg_id < IW'(SGI_IDS)
        |-> $countones(sgi_o) == 1 && sgi_o[cfg_cpu] != '0); // R8
endmodule

// File: rtl/mpid_cpu.sv
`timescale 1ns/1ps
module mpid_cpu
    import mpid_pkg::*;
#(
    parameter int NID = 40,
    localparam int IW = $clog2(NID)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NID-1:0]                en_i,
    input  logic [NID-1:0][PRIO_W-1:0]    prio_i,
    input  logic [NID-1:0]                set_i,
    input  logic                          ack_i,
    input  logic                          eoi_i,
    input  logic [IW-1:0]                 eoi_id_i,
    output logic                          irq_req_o,
    output logic [IW-1:0]                 irq_id_o
);
    localparam logic [PRIO_W:0] P_NONE = (PRIO_W+1)'(1 << PRIO_W);

    cell_st_e        st_q [NID];
    cell_st_e        st_d [NID];
    logic [PRIO_W:0] best_p, run_p;
    logic [IW-1:0]   best_id;
    logic            take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NID; i++) st_q[i] <= CS_IDLE;
        end else begin
            for (int i = 0; i < NID; i++) st_q[i] <= st_d[i];
        end
    end

    // next state for every cell
    always_comb begin
        for (int i = 0; i < NID; i++) begin
            st_d[i] = st_q[i];
            unique case (st_q[i])
                CS_IDLE: if (set_i[i]) st_d[i] = CS_PEND;
                CS_PEND: begin
                    if (take && best_id == IW'(i))      st_d[i] = CS_ACT;
                    else if (i >= SGI_IDS && !set_i[i]) st_d[i] = CS_IDLE;
                end
                CS_ACT: if (eoi_i && eoi_id_i == IW'(i)) st_d[i] = CS_IDLE;
                default: st_d[i] = CS_IDLE;
            endcase
        end
    end

    // outputs: most urgent pending ID against running priority
    always_comb begin
        best_p  = P_NONE;
        run_p   = P_NONE;
        best_id = '1;
        for (int i = 0; i < NID; i++) begin
            if (st_q[i] == CS_PEND && en_i[i] && {1'b0, prio_i[i]} < best_p) begin
                best_p  = {1'b0, prio_i[i]};
                best_id = IW'(i);
            end
            if (st_q[i] == CS_ACT && {1'b0, prio_i[i]} < run_p) run_p = {1'b0, prio_i[i]};
        end
    end

    assign irq_req_o = best_p < run_p;
    assign irq_id_o  = irq_req_o ? best_id : '1;
    assign take      = ack_i && irq_req_o;

    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> en_i[irq_id_o]); // R3

    for (genvar g = 0; g < NID; g++) begin : g_chk
        AST_NO_SKIP_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == CS_IDLE |=> st_q[g] != CS_ACT); // R5
        AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            ack_i && irq_req_o && irq_id_o == IW'(g) |=> st_q[g] == CS_ACT); // R5
        AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_i && eoi_id_i == IW'(g) && st_q[g] == CS_ACT |=> st_q[g] == CS_IDLE); // R7
    end
endmodule

// File: rtl/mpid_top.sv
`timescale 1ns/1ps
module mpid_top
    import mpid_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NHW  = 8,
    localparam int NID = HW_BASE + NHW,
    localparam int IW  = $clog2(NID),
    localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_op,
    input  logic [CW-1:0]        cfg_cpu,
    input  logic [IW-1:0]        cfg_id,
    input  logic [7:0]           cfg_data,
    input  logic [NHW-1:0]       hw_irq,
    input  logic [NCPU-1:0]      tmr_irq,
    input  logic [NCPU-1:0]      wdg_irq,
    input  logic [NCPU-1:0]      ack,
    input  logic [NCPU-1:0]      eoi,
    input  logic [NCPU*IW-1:0]   eoi_id,
    output logic [NCPU-1:0]      irq_req,
    output logic [NCPU*IW-1:0]   irq_id
);
    logic [NID-1:0]                       en_w;
    logic [NCPU-1:0][NID-1:0][PRIO_W-1:0] prio_w;
    logic [NHW-1:0][NCPU-1:0]             route_w;
    logic [NCPU-1:0][SGI_IDS-1:0]         sgi_w;
    logic [NCPU-1:0][NID-1:0]             set_w;

    mpid_cfg #(.NCPU(NCPU), .NHW(NHW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_cpu(cfg_cpu), .cfg_id(cfg_id), .cfg_data(cfg_data),
        .en_o(en_w), .prio_o(prio_w), .route_o(route_w), .sgi_o(sgi_w)
    );

    // source fan-out per CPU
    always_comb begin
        set_w = '0;
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < SGI_IDS; i++) set_w[c][i] = sgi_w[c][i];
            set_w[c][TMR_ID] = tmr_irq[c];
            set_w[c][WDG_ID] = wdg_irq[c];
            for (int h = 0; h < NHW; h++) set_w[c][HW_BASE+h] = hw_irq[h] & route_w[h][c];
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        mpid_cpu #(.NID(NID)) u_cpu (
            .clk(clk), .rst_n(rst_n), .en_i(en_w), .prio_i(prio_w[c]),
            .set_i(set_w[c]), .ack_i(ack[c]), .eoi_i(eoi[c]),
            .eoi_id_i(eoi_id[c*IW +: IW]),
            .irq_req_o(irq_req[c]), .irq_id_o(irq_id[c*IW +: IW])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> irq_req == '0); // R1
endmodule

// File: tb/sim_mpid_top.sv
`timescale 1ns/1ps
module sim_mpid_top;
    import mpid_pkg::*;
    localparam int NCPU = 4;
    localparam int NHW  = 8;
    localparam int NID  = HW_BASE + NHW;
    localparam int IW   = $clog2(NID);
    localparam int CW   = 2;
    localparam int NOID = (1 << IW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_op = '0;
    logic [CW-1:0] cfg_cpu = '0;
    logic [IW-1:0] cfg_id = '0;
    logic [7:0] cfg_data = '0;
    logic [NHW-1:0] hw_irq = '0;
    logic [NCPU-1:0] tmr_irq = '0, wdg_irq = '0, ack = '0, eoi = '0;
    logic [NCPU*IW-1:0] eoi_id = '0;
    logic [NCPU-1:0] irq_req;
    logic [NCPU*IW-1:0] irq_id;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    mpid_top #(.NCPU(NCPU), .NHW(NHW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_cpu(cfg_cpu),
        .cfg_id(cfg_id), .cfg_data(cfg_data), .hw_irq(hw_irq), .tmr_irq(tmr_irq),
        .wdg_irq(wdg_irq), .ack(ack), .eoi(eoi), .eoi_id(eoi_id),
        .irq_req(irq_req), .irq_id(irq_id)
    );

    always #2 clk = ~clk;

    // ---------------- requirement model ----------------
    int m_st [NCPU][NID];
    bit m_en [NID];
    int m_pr [NCPU][NID];
    bit [NCPU-1:0] m_rt [NHW];

    function automatic int m_best(int c);
        int bp = 16, bi = -1;
        for (int i = 0; i < NID; i++)
            if (m_st[c][i] == 1 && m_en[i] && m_pr[c][i] < bp) begin bp = m_pr[c][i]; bi = i; end
        return bi;
    endfunction

    function automatic int m_run(int c);
        int rp = 16;
        for (int i = 0; i < NID; i++)
            if (m_st[c][i] == 2 && m_pr[c][i] < rp) rp = m_pr[c][i];
        return rp;
    endfunction

    function automatic bit m_req(int c);
        int b = m_best(c);
        return b >= 0 && m_pr[c][b] < m_run(c);
    endfunction

    function automatic bit m_tgt(int c);
        case (cfg_data[1:0])
            2'd0: return cfg_data[2+c];
            2'd1: return c != int'(cfg_cpu);
            2'd2: return c == int'(cfg_cpu);
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int bs [NCPU];
        bit rq [NCPU];
        bit sv;
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++)
                for (int i = 0; i < NID; i++) begin m_st[c][i] = 0; m_pr[c][i] = 0; end
            for (int i = 0; i < NID; i++) m_en[i] = 0;
            for (int h = 0; h < NHW; h++) m_rt[h] = '0;
        end else begin
            for (int c = 0; c < NCPU; c++) begin bs[c] = m_best(c); rq[c] = m_req(c); end
            for (int c = 0; c < NCPU; c++)
                for (int i = 0; i < NID; i++) begin
                    sv = 0;
                    if (i < 16) sv = cfg_we && cfg_op == 2'd3 && int'(cfg_id) == i && m_tgt(c);
                    else if (i == 29) sv = tmr_irq[c];
                    else if (i == 30) sv = wdg_irq[c];
                    else if (i >= 32) sv = hw_irq[i-32] && m_rt[i-32][c];
                    case (m_st[c][i])
                        0: if (sv) m_st[c][i] = 1;
                        1: if (rq[c] && ack[c] && bs[c] == i) m_st[c][i] = 2;
                           else if (i >= 16 && !sv) m_st[c][i] = 0;
                        default: if (eoi[c] && int'(eoi_id[c*IW +: IW]) == i) m_st[c][i] = 0;
                    endcase
                end
            if (cfg_we && int'(cfg_id) < NID) begin
                case (cfg_op)
                    2'd0: m_en[cfg_id] = cfg_data[0];
                    2'd1: if (cfg_id < 32) m_pr[cfg_cpu][cfg_id] = int'(cfg_data[3:0]);
                          else for (int c = 0; c < NCPU; c++) m_pr[c][cfg_id] = int'(cfg_data[3:0]);
                    2'd2: if (cfg_id >= 32) m_rt[cfg_id-32] = cfg_data[NCPU-1:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic exact(string tag, int c, bit rq, int id);
        chk(tag, irq_req[c], rq);
        chk(tag, irq_id[c*IW +: IW], rq ? id : NOID);
    endtask

    task automatic cmp(string tag);
        for (int c = 0; c < NCPU; c++) begin
            chk(tag, irq_req[c], m_req(c));
            chk(tag, irq_id[c*IW +: IW], m_req(c) ? m_best(c) : NOID);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cfg_we = 0; ack = '0; eoi = '0;
    endtask

    task automatic wr(int op, int cpu, int id, int data);
        cfg_we = 1; cfg_op = 2'(op); cfg_cpu = CW'(cpu); cfg_id = IW'(id); cfg_data = 8'(data);
        tick();
    endtask

    task automatic set_eoi(int c, int id);
        eoi[c] = 1'b1;
        eoi_id[c*IW +: IW] = IW'(id);
    endtask

    task automatic do_reset();
        rst_n = 0; hw_irq = '0; tmr_irq = '0; wdg_irq = '0;
        cfg_we = 0; ack = '0; eoi = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        for (int c = 0; c < NCPU; c++) exact("R1 reset", c, 0, 0);

        // R2 routing and level withdraw
        wr(0, 0, 32, 1); wr(1, 0, 32, 5); wr(2, 0, 32, 4'b0011);
        hw_irq[0] = 1; tick();
        exact("R2 routed cpu0", 0, 1, 32); exact("R2 routed cpu1", 1, 1, 32);
        exact("R2 not routed cpu2", 2, 0, 0); exact("R2 not routed cpu3", 3, 0, 0);
        hw_irq[0] = 0; tick();
        exact("R2 withdraw cpu0", 0, 0, 0); cmp("R2");

        // R3 enable masking
        do_reset();
        wr(1, 0, 34, 1); wr(2, 0, 34, 1);
        hw_irq[2] = 1; tick(); tick();
        exact("R3 disabled", 0, 0, 0);
        wr(0, 0, 34, 1);
        exact("R3 enabled", 0, 1, 34);

        // R4 priority and tie
        do_reset();
        for (int i = 32; i <= 34; i++) begin wr(0, 0, i, 1); wr(2, 0, i, 1); end
        wr(1, 0, 32, 7); wr(1, 0, 33, 3); wr(1, 0, 34, 3);
        hw_irq[2:0] = 3'b111; tick();
        exact("R4 lowest value then lowest id", 0, 1, 33);

        // R5 / R6 acknowledge and preemption
        ack[0] = 1; tick();
        exact("R6 equal value no preempt", 0, 0, 0);
        wr(1, 0, 32, 2);
        exact("R6 strictly more urgent preempts", 0, 1, 32);
        ack[0] = 1; tick();
        exact("R5 taken", 0, 0, 0);
        set_eoi(0, 32); tick();
        exact("R7 finished", 0, 0, 0);
        tick();
        exact("R7 level re-pends", 0, 1, 32); cmp("R5");

        // R7 per-CPU independence
        do_reset();
        wr(0, 0, 35, 1); wr(1, 0, 35, 4); wr(2, 0, 35, 4'b1111);
        hw_irq[3] = 1; tick();
        for (int c = 0; c < NCPU; c++) exact("R2 all cpus", c, 1, 35);
        ack[0] = 1; tick();
        exact("R7 cpu0 took", 0, 0, 0); exact("R7 cpu1 still pending", 1, 1, 35);
        set_eoi(0, 35); hw_irq[3] = 0; tick();
        exact("R7 cpu0 done", 0, 0, 0); exact("R2 cpu1 withdrawn", 1, 0, 0);

        // R8 software targeting
        do_reset();
        wr(0, 0, 5, 1);
        wr(1, 0, 5, 9); wr(1, 1, 5, 2); wr(1, 2, 5, 4); wr(1, 3, 5, 6);
        wr(3, 1, 5, 1);
        exact("R8 others cpu0", 0, 1, 5); exact("R8 others not self", 1, 0, 0);
        exact("R8 others cpu2", 2, 1, 5); exact("R8 others cpu3", 3, 1, 5);
        ack = 4'b1111; tick();
        for (int c = 0; c < NCPU; c++) exact("R11 R5 after ack", c, 0, 0);
        wr(0, 0, 6, 1);
        for (int c = 0; c < NCPU; c++) wr(1, c, 6, 1);
        wr(3, 2, 6, 2);
        exact("R8 self", 2, 1, 6); exact("R8 self only", 0, 0, 0);
        wr(3, 0, 6, 8'b0010_0100);
        exact("R8 list cpu0", 0, 1, 6); exact("R8 list cpu3", 3, 1, 6);
        exact("R8 list skips cpu1", 1, 0, 0); cmp("R8");

        // R9 target banked priority
        do_reset();
        wr(0, 0, 32, 1); wr(1, 0, 32, 5); wr(2, 0, 32, 1);
        hw_irq[0] = 1; tick(); ack[0] = 1; tick();
        wr(0, 0, 7, 1); wr(1, 0, 7, 2); wr(1, 1, 7, 9);
        wr(3, 1, 7, 8'b0000_0100);
        exact("R9 target priority preempts", 0, 1, 7);

        // R10 private timer / watchdog, R11 ignored handshakes
        do_reset();
        wr(0, 0, 29, 1); wr(0, 0, 30, 1); wr(1, 2, 29, 4); wr(1, 3, 30, 3);
        tmr_irq[2] = 1; tick();
        exact("R10 timer cpu2", 2, 1, 29); exact("R10 timer not cpu0", 0, 0, 0);
        wdg_irq[3] = 1; tick();
        exact("R10 watchdog cpu3", 3, 1, 30); exact("R10 watchdog not cpu2", 2, 1, 29);
        set_eoi(2, 29); ack[1] = 1; tick();
        exact("R11 eoi on pending ignored", 2, 1, 29); exact("R11 idle id", 1, 0, 0);
        ack[2] = 1; tick();
        tmr_irq[2] = 0; tick();
        exact("R11 active stays", 2, 0, 0);

        // R12 ack and EOI together
        do_reset();
        for (int i = 32; i <= 34; i++) begin wr(0, 0, i, 1); wr(2, 0, i, 1); end
        wr(1, 0, 32, 5); wr(1, 0, 33, 1); wr(1, 0, 34, 6);
        hw_irq[0] = 1; tick(); ack[0] = 1; tick();
        hw_irq[0] = 0; hw_irq[1] = 1; hw_irq[2] = 1; tick();
        exact("R12 setup", 0, 1, 33);
        ack[0] = 1; set_eoi(0, 32); tick();
        exact("R12 both", 0, 0, 0);
        set_eoi(0, 33); hw_irq[1] = 0; tick();
        exact("R12 older released", 0, 1, 34);

        // random phase against the model
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0)
                wr_nb($urandom_range(0, 3), $urandom_range(0, NCPU-1),
                      ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) :
                      (($urandom_range(0, 1) == 0) ? $urandom_range(0, 15) : $urandom_range(29, NID-1)),
                      $urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) hw_irq = NHW'($urandom);
            if ($urandom_range(0, 7) == 0) tmr_irq = NCPU'($urandom);
            if ($urandom_range(0, 7) == 0) wdg_irq = NCPU'($urandom);
            ack = NCPU'($urandom);
            for (int c = 0; c < NCPU; c++) begin
                if ($urandom_range(0, 2) == 0) begin
                    int pick = $urandom_range(0, NID-1);
                    for (int i = 0; i < NID; i++) if (m_st[c][i] == 2) pick = i;
                    set_eoi(c, ($urandom_range(0, 4) == 0) ? $urandom_range(0, 63) : pick);
                end
            end
            tick();
            cmp("R4 R6 random");
        end

        done = 1;
        finish_up();
    end

    task automatic wr_nb(int op, int cpu, int id, int data);
        cfg_we = 1; cfg_op = 2'(op); cfg_cpu = CW'(cpu); cfg_id = IW'(id); cfg_data = 8'(data);
    endtask
endmodule